// File: doc/BRIEF.md
# Indexed Interrupt Routing Register File

This block holds the routing configuration for a bank of interrupt pins and lets a host reach it through two 32-bit locations. The first is a selector that picks a register number. The second is a data window that reads or writes the selected register. Behind the window sit four things: an identification register, a fixed version word, an arbitration word that mirrors the identification value, and a table with one 64-bit routing entry per pin. Each table entry is reached as two 32-bit halves.

Each entry carries two status bits that the host cannot write. The first is the pending-acknowledge flag. It is set by the downstream delivery logic through `rirr_set`, and only while the entry is level-triggered. The second is the in-flight flag, which this block never sets, so it always reads 0. A window write has two side effects. If it leaves an entry edge-triggered, the pending-acknowledge flag of that entry is dropped. If it leaves an entry level-triggered while that pin's input is high, the block issues a one-cycle delivery request for that pin.

All entries are always visible in parallel on `entry_cfg`, so the delivery logic can read them without using the bus.

Top module: `irq_route_regfile`

## Requirements
- R1: Only bus offsets 0x00 (selector) and 0x10 (window) respond, and only when `bus_size` is 4. Any other offset or size reads 0, and a write to it changes no state.
- R2: The selector stores all 32 written bits and reads them back. Its low 8 bits give the register number that the window acts on. For example, a selector value of 0x123 selects register 0x23.
- R3: Writing register 0x00 stores the data ANDed with `ID_MASK` (default 0xFF000000). Register 0x02 reads back the same stored value.
- R4: Register 0x01 reads ((NUM_ENTRIES-1) << 16) | 0x11, which is 0x001F0011 for 32 entries. Writes to register 0x01 or 0x02 change nothing.
- R5: Entry n sits at register 0x10+2n for bits [31:0] and at 0x10+2n+1 for bits [63:32]. A write touches only that half of that entry.
- R6: After reset, every entry reads 0x0001000000010000 (mask bit 16 set, all pins masked). The selector and the identification register read 0, and no delivery request is active.
- R7: Bit 12 (in-flight) and bit 14 (pending-acknowledge) are read-only. A low-half write keeps their stored values and replaces bits [11:0], bit 13 and bits [31:15].
- R8: When a write leaves bit 15 (trigger mode, 1 = level) at 0, bit 14 of that entry becomes 0.
- R9: When a write to either half of entry n leaves bit 15 at 1 while `pin_level[n]` is 1, `deliver_req[n]` is high for exactly the one cycle after the write edge. In every other case it stays 0.
- R10: A window read of any register number other than 0x00, 0x01, 0x02 or 0x10 to 0x10+2*NUM_ENTRIES-1 returns 0.
- R11: A pulse on `rirr_set[n]` sets bit 14 of entry n only while that entry is level-triggered. `entry_cfg[n*64 +: 64]` always equals entry n's stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_offset | input | 8 | Byte offset of the access |
| bus_size | input | 4 | Access width in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| pin_level | input | NUM_ENTRIES | Current asserted state of each pin |
| rirr_set | input | NUM_ENTRIES | Delivery logic sets pending-acknowledge |
| entry_cfg | output | NUM_ENTRIES*64 | All entries, entry n at bits [n*64 +: 64] |
| deliver_req | output | NUM_ENTRIES | One-cycle delivery request per pin |

## Verification
The bench builds the block with its defaults: 32 entries and an identification mask of 0xFF000000. With these values the version word is 0x001F0011, the last table half is register 0x4F and register 0x50 is the first number past the table, so the check for the exact end of the table is reachable. Masking the upper identification byte makes a stray written low bit visible on read-back. The defaults also reach a selector value whose upper bits must be ignored when decoding.

// File: rtl/irq_rf_pkg.sv
package irq_rf_pkg;
  localparam logic [7:0] REG_ID    = 8'h00;
  localparam logic [7:0] REG_VER   = 8'h01;
  localparam logic [7:0] REG_ARB   = 8'h02;
  localparam logic [7:0] TBL_BASE  = 8'h10;
  localparam logic [7:0] OFS_SEL   = 8'h00;
  localparam logic [7:0] OFS_WIN   = 8'h10;
  localparam logic [3:0] ACC_BYTES = 4'd4;

  localparam int unsigned BIT_INFLIGHT = 12;
  localparam int unsigned BIT_PENDACK  = 14;
  localparam int unsigned BIT_LEVEL    = 15;
  localparam logic [31:0] RO_LO_MASK   = 32'h0000_5000;
  localparam logic [63:0] ENTRY_RST    = 64'h0001_0000_0001_0000;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_ID,
    RK_VER,
    RK_ARB,
    RK_TBL
  } reg_kind_e;
endpackage

// File: rtl/irq_rf_decode.sv
module irq_rf_decode
  import irq_rf_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned IDX_W       = 5
) (
  input  logic [7:0]       regnum,
  output reg_kind_e        kind,
  output logic [IDX_W-1:0] entry_sel,
  output logic             sel_hi
);
  localparam logic [8:0] TBL_END = 9'(TBL_BASE) + 9'(2 * NUM_ENTRIES);

  logic [7:0] tbl_off;

  always_comb begin
    tbl_off   = regnum - TBL_BASE;
    entry_sel = tbl_off[IDX_W:1];
    sel_hi    = tbl_off[0];
    kind      = RK_NONE;
    if (regnum == REG_ID)       kind = RK_ID;
    else if (regnum == REG_VER) kind = RK_VER;
    else if (regnum == REG_ARB) kind = RK_ARB;
    else if (regnum >= TBL_BASE && {1'b0, regnum} < TBL_END) kind = RK_TBL;
  end
endmodule

// File: rtl/irq_rf_entry.sv
module irq_rf_entry
  import irq_rf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  input  logic        pin_level,
  output logic [63:0] cfg,
  output logic        deliver_req
);
  logic [63:0] cfg_q, cfg_d, merged;
  logic        req_q, req_d;

  always_comb begin
    merged = cfg_q;
    if (wr_lo) merged[31:0]  = (wdata & ~RO_LO_MASK) | (cfg_q[31:0] & RO_LO_MASK);
    if (wr_hi) merged[63:32] = wdata;
    cfg_d = merged;
    cfg_d[BIT_PENDACK] = merged[BIT_LEVEL] & (cfg_q[BIT_PENDACK] | rirr_set);
    req_d = (wr_lo | wr_hi) & merged[BIT_LEVEL] & pin_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= ENTRY_RST;
      req_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      req_q <= req_d;
    end
  end

  assign cfg         = cfg_q;
  assign deliver_req = req_q;

  assert_inflight_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[BIT_INFLIGHT]);
  assert_edge_no_pendack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[BIT_LEVEL] |-> !cfg_q[BIT_PENDACK]);
  assert_req_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> cfg_q[BIT_LEVEL]);
  assert_pendack_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && cfg_q[BIT_LEVEL] && wdata[BIT_LEVEL] && !rirr_set)
      |=> cfg_q[BIT_PENDACK] == $past(cfg_q[BIT_PENDACK]));
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
  import irq_rf_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 32,
  parameter logic [31:0] ID_MASK     = 32'hFF00_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_valid,
  input  logic                      bus_write,
  input  logic [7:0]                bus_offset,
  input  logic [3:0]                bus_size,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [NUM_ENTRIES-1:0]    pin_level,
  input  logic [NUM_ENTRIES-1:0]    rirr_set,
  output logic [NUM_ENTRIES*64-1:0] entry_cfg,
  output logic [NUM_ENTRIES-1:0]    deliver_req
);
  localparam int unsigned IDX_W   = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [31:0] VERSION = (32'(NUM_ENTRIES - 1) << 16) | 32'h0000_0011;

  logic [31:0]      idx_q, idx_d, id_q, id_d;
  logic             acc_ok, sel_wr, win_wr, win_rd, sel_rd;
  reg_kind_e        kind;
  logic [IDX_W-1:0] entry_sel;
  logic             sel_hi;
  logic [63:0]      cfg_arr [NUM_ENTRIES];

  assign acc_ok = bus_valid && (bus_size == ACC_BYTES);
  assign sel_wr = acc_ok &&  bus_write && (bus_offset == OFS_SEL);
  assign sel_rd = acc_ok && !bus_write && (bus_offset == OFS_SEL);
  assign win_wr = acc_ok &&  bus_write && (bus_offset == OFS_WIN);
  assign win_rd = acc_ok && !bus_write && (bus_offset == OFS_WIN);

  irq_rf_decode #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_dec (
    .regnum   (idx_q[7:0]),
    .kind     (kind),
    .entry_sel(entry_sel),
    .sel_hi   (sel_hi)
  );

  always_comb begin
    idx_d = idx_q;
    id_d  = id_q;
    if (sel_wr) idx_d = bus_wdata;
    if (win_wr && kind == RK_ID) id_d = bus_wdata & ID_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      id_q  <= '0;
    end else begin
      idx_q <= idx_d;
      id_q  <= id_d;
    end
  end

  for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_ent
    logic hit;
    assign hit = win_wr && (kind == RK_TBL) && (entry_sel == IDX_W'(n));
    irq_rf_entry u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_lo      (hit && !sel_hi),
      .wr_hi      (hit && sel_hi),
      .wdata      (bus_wdata),
      .rirr_set   (rirr_set[n]),
      .pin_level  (pin_level[n]),
      .cfg        (cfg_arr[n]),
      .deliver_req(deliver_req[n])
    );
    assign entry_cfg[n*64 +: 64] = cfg_arr[n];
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_rd) bus_rdata = idx_q;
    else if (win_rd) begin
      case (kind)
        RK_ID:   bus_rdata = id_q;
        RK_VER:  bus_rdata = VERSION;
        RK_ARB:  bus_rdata = id_q;
        RK_TBL:  bus_rdata = sel_hi ? cfg_arr[entry_sel][63:32] : cfg_arr[entry_sel][31:0];
        default: bus_rdata = '0;
      endcase
    end
  end

  assert_tbl_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == RK_TBL) |-> (32'(entry_sel) < NUM_ENTRIES));
  assert_req_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|deliver_req) |-> $past(win_wr));
  assert_single_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(deliver_req));
endmodule

// File: tb/irq_route_regfile_tb.sv
module irq_route_regfile_tb_top;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]    bus_offset = '0;
  logic [3:0]    bus_size = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pin_level = '0, rirr_set = '0;
  logic [N*64-1:0] entry_cfg;
  logic [N-1:0]  deliver_req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_route_regfile #(.NUM_ENTRIES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_offset(bus_offset), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_level(pin_level), .rirr_set(rirr_set),
    .entry_cfg(entry_cfg), .deliver_req(deliver_req)
  );

  // {req[81:78], chk[77], wr[76], off[75:68], size[67:64], data[63:32], exp[31:0]}
  localparam int NV = 32;
  localparam logic [81:0] VEC [NV] = '{
    {4'd2,  1'b0, 1'b1, 8'h00, 4'd4, 32'h0000_0001, 32'h0},           // R2 select version
    {4'd4,  1'b1, 1'b0, 8'h10, 4'd4, 32'h0,         32'h001F_0011},   // R4
    {4'd4,  1'b0, 1'b1, 8'h10, 4'd4, 32'hFFFF_FFFF, 32'h0},           // R4 write ignored
    {4'd4,  1'b1, 1'b0, 8'h10, 4'd4, 32'h0,         32'h001F_0011},   // R4
    {4'd3,  1'b0, 1'b1, 8'h00, 4'd4, 32'h0,         32'h0},           // R3 select id
    {4'd3,  1'b0, 1'b1, 8'h10, 4'd4, 32'hABCD_EF12, 32'h0},           // R3
    {4'd3,  1'b1, 1'b0, 8'h10, 4'd4, 32'h0,         32'hAB00_0000},   // R3 masked
    {4'd3,  1'b0, 1'b1, 8'h00, 4'd4, 32'h0000_0002, 32'h0},           // R3 select arb
    {4'd3,  1'b1, 1'b0, 8'h10, 4'd4, 32'h0,         32'hAB00_0000},   // R3 arb mirrors id
    {4'd4,  1'b0, 1'b1, 8'h10, 4'd4, 32'h0,         32'h0},           // R4 arb write ignored
    {4'd4,  1'b1, 1'b0, 8'h10, 4'd4, 32'h0,         32'hAB00_0000},   // R4
    {4'd2,  1'b1, 1'b0, 8'h00, 4'd4, 32'h0,         32'h0000_0002},   // R2 selector readback
    {4'd6,  1'b0, 1'b1, 8'h00, 4'd4, 32'h0000_0010, 32'h0},           // R6
    {4'd6,  1'b1, 1'b0, 8'h10, 4'd4, 32'h0,         32'h0001_0000},   // R6 entry0 lo
    {4'd6,  1'b0, 1'b1, 8'h00, 4'd4, 32'h0000_004F, 32'h0},           // R6
    {4'd6,  1'b1, 1'b0, 8'h10, 4'd4, 32'h0,         32'h0001_0000},   // R6 entry31 hi
    {4'd10, 1'b0, 1'b1, 8'h00, 4'd4, 32'h0000_0050, 32'h0},           // R10 past table
    {4'd10, 1'b1, 1'b0, 8'h10, 4'd4, 32'h0,         32'h0},           // R10
    {4'd10, 1'b0, 1'b1, 8'h00, 4'd4, 32'h0000_0003, 32'h0},           // R10 gap
    {4'd10, 1'b1, 1'b0, 8'h10, 4'd4, 32'h0,         32'h0},           // R10
    {4'd7,  1'b0, 1'b1, 8'h00, 4'd4, 32'h0000_0010, 32'h0},           // R7
    {4'd7,  1'b0, 1'b1, 8'h10, 4'd4, 32'hFFFF_FFFF, 32'h0},           // R7 all ones
    {4'd7,  1'b1, 1'b0, 8'h10, 4'd4, 32'h0,         32'hFFFF_AFFF},   // R7 ro bits stay 0
    {4'd1,  1'b1, 1'b0, 8'h10, 4'd2, 32'h0,         32'h0},           // R1 bad size read
    {4'd1,  1'b0, 1'b1, 8'h10, 4'd2, 32'h0,         32'h0},           // R1 bad size write
    {4'd1,  1'b1, 1'b0, 8'h10, 4'd4, 32'h0,         32'hFFFF_AFFF},   // R1 unchanged
    {4'd1,  1'b1, 1'b0, 8'h04, 4'd4, 32'h0,         32'h0},           // R1 bad offset read
    {4'd1,  1'b0, 1'b1, 8'h04, 4'd4, 32'h0000_0077, 32'h0},           // R1 bad offset write
    {4'd1,  1'b1, 1'b0, 8'h00, 4'd4, 32'h0,         32'h0000_0010},   // R1 selector unchanged
    {4'd2,  1'b0, 1'b1, 8'h00, 4'd4, 32'h0000_0123, 32'h0},           // R2 upper bits ignored
    {4'd2,  1'b1, 1'b0, 8'h00, 4'd4, 32'h0,         32'h0000_0123},   // R2
    {4'd5,  1'b1, 1'b0, 8'h10, 4'd4, 32'h0,         32'h0001_0000}    // R5 entry9 hi
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic [7:0] off, input logic [3:0] sz,
                    input logic [31:0] data);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_offset = off; bus_size = sz; bus_wdata = data;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    #2;
  endtask

  task automatic rd_reg(input logic [7:0] rn, input string req, input logic [31:0] exp);
    op(1'b1, 8'h00, 4'd4, {24'h0, rn});
    op(1'b0, 8'h10, 4'd4, 32'h0);
    check(req, {32'h0, bus_rdata}, {32'h0, exp});
  endtask

  task automatic wr_reg(input logic [7:0] rn, input logic [31:0] data);
    op(1'b1, 8'h00, 4'd4, {24'h0, rn});
    op(1'b1, 8'h10, 4'd4, data);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R6 reset state
    op(1'b0, 8'h00, 4'd4, 32'h0);
    check("R6 selector", {32'h0, bus_rdata}, 64'h0);
    check("R6 entry3", entry_cfg[3*64 +: 64], 64'h0001_0000_0001_0000);
    check("R6 req", {32'h0, deliver_req}, 64'h0);
    idle();

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][76], VEC[i][75:68], VEC[i][67:64], VEC[i][63:32]);
      if (VEC[i][77]) begin
        checks++;
        if (bus_rdata !== VEC[i][31:0]) begin
          errors++;
          $display("FAIL R%0d row %0d actual=%h expected=%h", VEC[i][81:78], i,
                   bus_rdata, VEC[i][31:0]);
        end
      end
    end
    idle();

    // R5 / R11: last entry high half, neighbour untouched
    wr_reg(8'h4F, 32'hFF00_0000);
    idle();
    check("R5 entry31", entry_cfg[31*64 +: 64], 64'hFF00_0000_0001_0000);
    check("R5 entry30", entry_cfg[30*64 +: 64], 64'h0001_0000_0001_0000);

    // R11 / R7 / R8: pending-acknowledge on entry 3 (regs 0x16/0x17)
    wr_reg(8'h16, 32'h0000_8030);
    idle();
    check("R9 no req pin low", {32'h0, deliver_req}, 64'h0);
    @(negedge clk) rirr_set = 32'h8;
    @(negedge clk) rirr_set = '0;
    #2;
    check("R11 pendack set", entry_cfg[3*64 +: 64], 64'h0001_0000_0000_C030);
    wr_reg(8'h16, 32'h0000_8031);
    idle();
    rd_reg(8'h16, "R7 pendack kept", 32'h0000_C031);
    wr_reg(8'h16, 32'h0000_0031);
    idle();
    rd_reg(8'h16, "R8 pendack cleared", 32'h0000_0031);
    @(negedge clk) rirr_set = 32'h8;
    @(negedge clk) rirr_set = '0;
    #2;
    check("R11 edge ignores set", entry_cfg[3*64 +: 64], 64'h0001_0000_0000_0031);

    // R9: retrigger on entry 5 (regs 0x1A/0x1B)
    pin_level = 32'h20;
    wr_reg(8'h1A, 32'h0000_8040);
    idle();
    check("R9 req pulse", {32'h0, deliver_req}, 64'h20);
    idle();
    check("R9 req one cycle", {32'h0, deliver_req}, 64'h0);
    wr_reg(8'h1B, 32'h0500_0000);
    idle();
    check("R9 hi write retrigger", {32'h0, deliver_req}, 64'h20);
    wr_reg(8'h1A, 32'h0000_0040);
    idle();
    check("R9 edge no req", {32'h0, deliver_req}, 64'h0);
    check("R11 mirror", entry_cfg[5*64 +: 64], 64'h0500_0000_0000_0040);

    idle();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule